// File: doc/BRIEF.md
# Dynamic Bus Sizing Cycle Splitter

This block sits on the master side of a 32-bit processor bus. It takes one access request at a time: a word address, four byte enables, a read/write flag and, for writes, a 32-bit data word. It then runs as many external bus cycles as it needs to move every enabled byte. On each cycle the slave states its port width through two active-low size inputs, sampled together with the ready that ends the cycle. When that width leaves bytes untransferred, the block does not finish. It starts another cycle with a fresh address strobe and narrower byte enables.

For reads, the bytes are gathered from the low lanes of the bus and placed into a 32-bit result word. For writes, the byte or half-word being sent is also copied down onto the low lanes, so a narrow slave finds it on the lines it is wired to. The last-cycle output is given only on the cycle whose ready completes the request. A one-clock done pulse follows, with the assembled read data.

Top module: `bus_size_splitter`

## Requirements
- R1: While reset is held and while idle, the address strobe, last-cycle output and all four byte-enable outputs are high (inactive), and done is low.
- R2: A request with at least one enabled byte, presented while idle, is accepted at a clock edge. In the next clock the address strobe is low for exactly one cycle. The bus byte enables equal the requested bytes. The block then waits in the data phase until ready is low.
- R3: At the ready edge the size inputs are decoded as follows. A low 8-bit input means a one-byte port, whatever the 16-bit input is. A low 16-bit input alone means a two-byte port. Both inputs high mean a full four-byte port.
- R4: If bytes remain after a ready, a new cycle starts on the next clock with the address strobe low again. Its byte enables depend on the width just reported. After an 8-bit report they are the single lowest remaining byte. After a 16-bit report they are the remaining bytes of the lowest aligned half (lanes 1:0, or lanes 3:2 if nothing is left in 1:0). After a 32-bit report they are all remaining bytes.
- R5: During the data phase the last-cycle output is low only when the bytes moved at this ready, given the current size inputs, leave nothing pending. It is high in every other cycle.
- R6: For reads, data is taken from bus bits 7:0 for an 8-bit port, bits 15:0 for a 16-bit port (lane k from bits of lane k mod 2) and all lanes for a 32-bit port. It is placed only into the lanes moved in that cycle. Lanes that were not requested read as zero.
- R7: For writes, the bus carries the request word. If byte enables 1:0 are both inactive, bits 15:0 carry bits 31:16. If byte enable 0 is inactive, bits 7:0 carry the lowest enabled byte.
- R8: Done is high for exactly one clock, in the cycle after the final ready, and the read result is valid from then on.
- R9: A request with all byte enables low, or a request presented while a transfer is under way, is ignored and starts no bus cycle.
- R10: A three-byte request (lanes 2:0) answered as 8-bit on every cycle completes in exactly three bus cycles.
- R11: Size inputs seen in wait states (ready high) have no effect; only their value at the ready edge counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_addr | input | AW | Word address of the request |
| req_be | input | 4 | Requested byte lanes, active high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data in natural lanes |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Assembled read data |
| bus_addr | output | AW | Bus word address |
| bus_ads_n | output | 1 | Address strobe, active low |
| bus_be_n | output | 4 | Byte enables, active low |
| bus_wr | output | 1 | Bus write flag |
| bus_wdata | output | 32 | Bus write data with low-lane copies |
| bus_rdata | input | 32 | Bus read data |
| bus_rdy_n | input | 1 | Cycle ready, active low |
| bus_sz16_n | input | 1 | Slave is 16 bits wide, active low |
| bus_sz8_n | input | 1 | Slave is 8 bits wide, active low |
| bus_blast_n | output | 1 | Last cycle of the request, active low |

## Verification
The checker watches, on every clock, several properties. The address strobe lasts one clock. The last-cycle output never shows outside the data phase. A ready without the last-cycle output is followed at once by a new strobe, whose byte enables fit the width just reported. A ready with the last-cycle output is followed by a single done pulse. Only the bench's scenarios can show the full byte-enable sequence, the exact cycle count, the assembled read word, and where the written bytes land for each mix of enables and per-cycle widths. They also show that wait-state size noise and requests made while busy change nothing.

// File: rtl/bss_pkg.sv
package bss_pkg;
    localparam int LANES = 4;
    localparam int BUS_W = 8 * LANES;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } bss_state_e;

    typedef enum logic [1:0] {
        WID_32 = 2'd0,
        WID_16 = 2'd1,
        WID_8  = 2'd2
    } bss_width_e;
endpackage

// File: rtl/bss_size_decode.sv
module bss_size_decode
    import bss_pkg::*;
(
    input  logic       sz16_n,
    input  logic       sz8_n,
    output bss_width_e width
);
    // 8-bit report wins when both are low
    always_comb begin
        if (!sz8_n)       width = WID_8;
        else if (!sz16_n) width = WID_16;
        else              width = WID_32;
    end
endmodule

// File: rtl/bss_lane_fit.sv
module bss_lane_fit
    import bss_pkg::*;
(
    input  logic [LANES-1:0] mask,
    input  bss_width_e       width,
    output logic [LANES-1:0] sel
);
    logic [LANES-1:0] lowest;

    always_comb begin
        lowest = mask & (~mask + {{(LANES-1){1'b0}}, 1'b1});
        case (width)
            WID_8:   sel = lowest;
            WID_16:  sel = (|mask[1:0]) ? {2'b00, mask[1:0]} : {mask[3:2], 2'b00};
            default: sel = mask;
        endcase
    end
endmodule

// File: rtl/bss_rd_merge.sv
module bss_rd_merge
    import bss_pkg::*;
(
    input  logic [BUS_W-1:0] acc,
    input  logic [BUS_W-1:0] bus,
    input  logic [LANES-1:0] xfer,
    input  bss_width_e       width,
    output logic [BUS_W-1:0] merged
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int HK = k % 2;
        logic [7:0] src;
        always_comb begin
            case (width)
                WID_8:   src = bus[7:0];
                WID_16:  src = bus[8*HK +: 8];
                default: src = bus[8*k +: 8];
            endcase
            merged[8*k +: 8] = xfer[k] ? src : acc[8*k +: 8];
        end
    end
endmodule

// File: rtl/bss_wr_align.sv
module bss_wr_align
    import bss_pkg::*;
(
    input  logic [BUS_W-1:0] word,
    input  logic [LANES-1:0] be,
    output logic [BUS_W-1:0] data
);
    always_comb begin
        data = word;
        if (be[1:0] == 2'b00) data[15:0] = word[31:16];
        if (!be[0]) begin
            if (be[1])      data[7:0] = word[15:8];
            else if (be[2]) data[7:0] = word[23:16];
            else            data[7:0] = word[31:24];
        end
    end
endmodule

// File: rtl/bus_size_splitter.sv
module bus_size_splitter
    import bss_pkg::*;
#(
    parameter int AW = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    input  logic [3:0]       req_be,
    input  logic             req_write,
    input  logic [31:0]      req_wdata,
    output logic             done,
    output logic [31:0]      rdata,
    output logic [AW-1:0]    bus_addr,
    output logic             bus_ads_n,
    output logic [3:0]       bus_be_n,
    output logic             bus_wr,
    output logic [31:0]      bus_wdata,
    input  logic [31:0]      bus_rdata,
    input  logic             bus_rdy_n,
    input  logic             bus_sz16_n,
    input  logic             bus_sz8_n,
    output logic             bus_blast_n
);
    typedef struct packed {
        bss_state_e       state;
        logic [LANES-1:0] pend;
        logic [LANES-1:0] cur_be;
        logic [BUS_W-1:0] rdata;
        logic [BUS_W-1:0] wdata;
        logic [AW-1:0]    addr;
        logic             write;
        logic             done;
    } regs_t;

    regs_t r_d, r_q;

    bss_width_e       width_now;
    logic [LANES-1:0] xfer, pend_after, next_be;
    logic [BUS_W-1:0] merged;
    logic             in_data;

    bss_size_decode u_dec (
        .sz16_n (bus_sz16_n),
        .sz8_n  (bus_sz8_n),
        .width  (width_now)
    );

    // bytes moved by this ready
    bss_lane_fit u_fit_xfer (
        .mask  (r_q.cur_be),
        .width (width_now),
        .sel   (xfer)
    );

    assign pend_after = r_q.pend & ~xfer;

    // enables for the follow-on cycle
    bss_lane_fit u_fit_next (
        .mask  (pend_after),
        .width (width_now),
        .sel   (next_be)
    );

    bss_rd_merge u_merge (
        .acc    (r_q.rdata),
        .bus    (bus_rdata),
        .xfer   (xfer),
        .width  (width_now),
        .merged (merged)
    );

    bss_wr_align u_align (
        .word (r_q.wdata),
        .be   (r_q.cur_be),
        .data (bus_wdata)
    );

    assign in_data = (r_q.state == ST_DATA);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid && (|req_be)) begin
                    r_d.state  = ST_ADDR;
                    r_d.pend   = req_be;
                    r_d.cur_be = req_be;
                    r_d.addr   = req_addr;
                    r_d.write  = req_write;
                    r_d.wdata  = req_wdata;
                    r_d.rdata  = '0;
                end
            end
            ST_ADDR: r_d.state = ST_DATA;
            ST_DATA: begin
                if (!bus_rdy_n) begin
                    if (!r_q.write) r_d.rdata = merged;
                    r_d.pend = pend_after;
                    if (pend_after == '0) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.state  = ST_ADDR;
                        r_d.cur_be = next_be;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done        = r_q.done;
    assign rdata       = r_q.rdata;
    assign bus_addr    = r_q.addr;
    assign bus_wr      = r_q.write;
    assign bus_ads_n   = (r_q.state != ST_ADDR);
    assign bus_be_n    = (r_q.state == ST_IDLE) ? 4'hF : ~r_q.cur_be;
    assign bus_blast_n = !(in_data && (pend_after == '0));
endmodule

// File: rtl/bss_checker.sv
module bss_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ads_n,
    input logic       blast_n,
    input logic       rdy_n,
    input logic       sz16_n,
    input logic       sz8_n,
    input logic [3:0] be_n,
    input logic       done,
    input logic       in_data
);
    assert_ads_one_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |=> ads_n);

    assert_blast_in_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !blast_n |-> (ads_n && in_data));

    assert_last_gives_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !rdy_n && !blast_n) |=> done);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_more_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !rdy_n && blast_n) |=> !ads_n);

    assert_byte_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !rdy_n && blast_n && !sz8_n) |=> ($countones(~be_n) == 1));

    assert_half_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !rdy_n && blast_n && sz8_n && !sz16_n) |=>
        ((be_n[3:2] == 2'b11) || (be_n[1:0] == 2'b11)));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_data && ads_n && !done && $past(!in_data && ads_n)) |-> (be_n == 4'hF || !ads_n || blast_n));
endmodule

bind bus_size_splitter bss_checker chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ads_n   (bus_ads_n),
    .blast_n (bus_blast_n),
    .rdy_n   (bus_rdy_n),
    .sz16_n  (bus_sz16_n),
    .sz8_n   (bus_sz8_n),
    .be_n    (bus_be_n),
    .done    (done),
    .in_data (in_data)
);

// File: tb/bus_size_splitter_tb.sv
`timescale 1ns/1ps
module bus_size_splitter_tb_top;
    localparam int AW = 30;
    localparam int NV = 11;
    // {be[3:0], widths per cycle 2b each (cycle0 in [1:0]; 0=32,1=16,2=8,3=both low),
    //  cycle count[2:0], be sequence (cycle0 in [3:0])}
    localparam logic [30:0] VECS [0:NV-1] = '{
        {4'hF, 8'h00, 3'd1, 16'h000F},
        {4'h7, 8'hAA, 3'd3, 16'h0427},
        {4'hF, 8'h55, 3'd2, 16'h00CF},
        {4'hF, 8'hAA, 3'd4, 16'h842F},
        {4'hF, 8'h29, 3'd3, 16'h08CF},
        {4'hE, 8'h02, 3'd3, 16'h084E},
        {4'h6, 8'h55, 3'd2, 16'h0046},
        {4'h8, 8'hFF, 3'd1, 16'h0008},
        {4'hC, 8'hAA, 3'd2, 16'h008C},
        {4'h3, 8'h00, 3'd1, 16'h0003},
        {4'h5, 8'h55, 3'd2, 16'h0045}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_be = '0;
    logic          req_write = 1'b0;
    logic [31:0]   req_wdata = '0;
    logic          done;
    logic [31:0]   rdata;
    logic [AW-1:0] bus_addr;
    logic          bus_ads_n;
    logic [3:0]    bus_be_n;
    logic          bus_wr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata = '0;
    logic          bus_rdy_n = 1'b1;
    logic          bus_sz16_n = 1'b1;
    logic          bus_sz8_n = 1'b1;
    logic          bus_blast_n;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] store;

    always #4 clk = ~clk;

    bus_size_splitter #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_be(req_be), .req_write(req_write), .req_wdata(req_wdata),
        .done(done), .rdata(rdata), .bus_addr(bus_addr), .bus_ads_n(bus_ads_n),
        .bus_be_n(bus_be_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rdy_n(bus_rdy_n), .bus_sz16_n(bus_sz16_n),
        .bus_sz8_n(bus_sz8_n), .bus_blast_n(bus_blast_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        for (int i = 0; i < 4; i++) lane_mask[8*i +: 8] = be[i] ? 8'hFF : 8'h00;
    endfunction

    function automatic int low_lane(input logic [3:0] be);
        low_lane = 3;
        for (int i = 3; i >= 0; i--) if (be[i]) low_lane = i;
    endfunction

    // slave: drive ready with a width, return data / capture written bytes
    task automatic slave_ready(input logic [1:0] code, input logic [3:0] be, input logic [31:0] mem);
        int ll;
        logic [15:0] half;
        ll = low_lane(be);
        bus_rdy_n  = 1'b0;
        bus_sz8_n  = !(code[1]);
        bus_sz16_n = !(code == 2'd1 || code == 2'd3);
        if (code == 2'd0) begin
            bus_rdata = mem;
        end else if (code == 2'd1) begin
            half = (|be[1:0]) ? mem[15:0] : mem[31:16];
            bus_rdata = {16'hBEEF, half};
        end else begin
            bus_rdata = {24'hA5A5A5, mem[8*ll +: 8]};
        end
        #1;
        if (bus_wr) begin
            if (code == 2'd0) begin
                for (int i = 0; i < 4; i++) if (be[i]) store[8*i +: 8] = bus_wdata[8*i +: 8];
            end else if (code == 2'd1) begin
                if (|be[1:0]) begin
                    for (int i = 0; i < 2; i++) if (be[i]) store[8*i +: 8] = bus_wdata[8*i +: 8];
                end else begin
                    for (int i = 2; i < 4; i++) if (be[i]) store[8*i +: 8] = bus_wdata[8*(i-2) +: 8];
                end
            end else begin
                store[8*ll +: 8] = bus_wdata[7:0];
            end
        end
    endtask

    task automatic run_vec(input logic [30:0] v, input bit wr, input logic [31:0] mem,
                           input bit wait_st, input bit poke, input int idx);
        logic [3:0]  be;
        logic [7:0]  wid;
        int          ncyc;
        logic [15:0] seq;
        logic [3:0]  cur;
        int          seen;
        be = v[30:27]; wid = v[26:19]; ncyc = int'(v[18:16]); seq = v[15:0];
        store = '0;
        seen  = 0;
        @(negedge clk);
        req_valid = 1'b1; req_be = be; req_write = wr; req_wdata = mem;
        req_addr = AW'(idx * 4 + 32'h100);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < ncyc; k++) begin
            chk(!bus_ads_n, "R2 strobe low at cycle start", {31'b0, bus_ads_n}, 32'd0);
            if (!bus_ads_n) seen++;
            chk(bus_be_n == ~seq[4*k +: 4], "R3 R4 byte-enable sequence", {28'b0, bus_be_n}, {28'b0, ~seq[4*k +: 4]});
            cur = ~bus_be_n;
            @(negedge clk);
            if (poke) begin
                req_valid = 1'b1; req_be = 4'h1;
            end
            chk(bus_ads_n, "R2 strobe high in data phase", {31'b0, bus_ads_n}, 32'd1);
            if (wait_st) begin
                bus_sz8_n = 1'b0; bus_sz16_n = 1'b0;
                @(negedge clk);
            end
            slave_ready(wid[2*k +: 2], cur, mem);
            chk(bus_blast_n == (k != ncyc - 1), "R5 last-cycle output at ready",
                {31'b0, bus_blast_n}, {31'b0, k != ncyc - 1});
            @(negedge clk);
            bus_rdy_n = 1'b1; bus_sz8_n = 1'b1; bus_sz16_n = 1'b1;
            req_valid = 1'b0;
        end
        chk(done, "R8 done after final ready", {31'b0, done}, 32'd1);
        if (wait_st) chk(seen == ncyc && bus_ads_n, "R11 wait-state size noise ignored", seen, ncyc);
        if (idx == 1) chk(seen == 3, "R10 three-byte 8-bit request cycles", seen, 3);
        if (wr) chk(store == (mem & lane_mask(be)), "R7 written lanes", store, mem & lane_mask(be));
        else    chk(rdata == (mem & lane_mask(be)), "R6 assembled read data", rdata, mem & lane_mask(be));
        @(negedge clk);
        chk(!done, "R8 done lasts one clock", {31'b0, done}, 32'd0);
        chk(bus_ads_n, "R9 no cycle after completion", {31'b0, bus_ads_n}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(bus_ads_n && bus_blast_n && bus_be_n == 4'hF && !done, "R1 reset state",
            {26'b0, bus_ads_n, bus_blast_n, bus_be_n}, {26'b0, 6'b111111});
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_ads_n && bus_be_n == 4'hF && !done, "R1 idle state",
            {27'b0, bus_ads_n, bus_be_n}, {27'b0, 5'b11111});

        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < NV; i++) begin
                run_vec(VECS[i], pass == 1, 32'h11223344 ^ (32'h0F1E2D3C * (i + 1)),
                        (i % 2) == 1, 1'b0, i);
            end
        end

        // R9: empty byte mask is ignored
        @(negedge clk);
        req_valid = 1'b1; req_be = 4'h0;
        @(negedge clk);
        req_valid = 1'b0;
        for (int j = 0; j < 3; j++) begin
            chk(bus_ads_n, "R9 empty request ignored", {31'b0, bus_ads_n}, 32'd1);
            @(negedge clk);
        end

        // R9: request while busy is ignored
        run_vec(VECS[3], 1'b0, 32'hCAFEF00D, 1'b0, 1'b1, 20);
        // R11 + R3: wait-state noise then full-width ready
        run_vec(VECS[0], 1'b0, 32'h76543210, 1'b1, 1'b0, 21);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule